// File: doc/BRIEF.md
# Banked Segmented Output Queue Manager

This block keeps many circular message queues inside one shared on-chip buffer. Each queue occupies a contiguous run of 32-entry chunks inside a 1024-entry window. The window is picked by a per-queue base value that the queue's first and last chunk numbers share, so a queue never straddles a window boundary. For every queue the block holds a read position (head), a write position (tail) and an occupancy count. It also raises a full flag and an empty flag for each queue.

A queue's window base, first chunk and last chunk are set through a configuration write port. An enqueue port stores a message at the tail of the named queue, and a dequeue port returns the message at its head one cycle later. The buffer is split across eight single-port SRAM banks. Neighbouring entries of a queue fall in neighbouring banks, so an enqueue and a dequeue can both complete in one cycle unless they need the same bank.

The default build has four windows (4096 entries) so that it elaborates quickly. Setting `BASE_W` to 5 gives the full 32K-entry buffer.

Top module: `oqm_top`

## Requirements
- R1: While reset is held (synchronous, active low), and after it is released, every queue reads empty and not full, and `rd_valid` is low.
- R2: A queue set up with first chunk S and last chunk E holds exactly (E-S+1)*32 messages. Its full flag rises on the enqueue that brings the count to that capacity and stays low below it. Its empty flag is high exactly when the count is zero.
- R3: Messages leave a queue in the order they were accepted, and each keeps its data unchanged.
- R4: The entry address is {base, window pointer}. The pointer moves from the last entry of chunk E back to the first entry of chunk S. Queues that share a window never overwrite each other.
- R5: An enqueue to a full queue raises `enq_err` in that cycle. It is not stored, and the queue's state does not change.
- R6: A dequeue from an empty queue raises `deq_err` in that cycle, produces no `rd_valid`, and does not change the queue.
- R7: The physical bank is given by bits 2:0 of the entry address. An enqueue and a dequeue that map to different banks are both accepted in the same cycle, including when they target the same queue.
- R8: When an accepted dequeue and an enqueue map to the same bank, the dequeue goes ahead. `enq_ready` is low in that cycle, and the enqueue is not accepted.
- R9: The cycle after a dequeue is accepted, `rd_valid` is high, `rd_qid` carries that queue id, and `rd_data` carries the head message.
- R10: A configuration write moves the queue's head and tail to the first entry of its first chunk and clears its count. This takes priority over an enqueue or dequeue to the same queue in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_qid | input | QID_W | Queue being configured |
| cfg_base | input | BASE_W | Window base (entry address bits above 9) |
| cfg_start | input | 5 | First chunk of the queue |
| cfg_end | input | 5 | Last chunk of the queue |
| enq_valid | input | 1 | Enqueue request |
| enq_qid | input | QID_W | Enqueue target queue |
| enq_data | input | DATA_W | Message to store |
| enq_ready | output | 1 | Low when the enqueue is stalled by a bank clash |
| enq_err | output | 1 | Enqueue rejected because the queue is full |
| deq_valid | input | 1 | Dequeue request |
| deq_qid | input | QID_W | Dequeue source queue |
| deq_err | output | 1 | Dequeue rejected because the queue is empty |
| rd_valid | output | 1 | Dequeued message valid |
| rd_qid | output | QID_W | Queue of the dequeued message |
| rd_data | output | DATA_W | Dequeued message |
| q_full | output | NUM_Q | Per-queue full flags |
| q_empty | output | NUM_Q | Per-queue empty flags |

## Verification
Some properties are checked by assertions on every cycle. These cover the state after reset, that full and empty are never both set, that a stall always comes from an accepted dequeue, the one-cycle return timing and queue id of a read, the absence of a read after a rejected dequeue, that a full queue stays full after a rejected enqueue, and that a queue is empty right after a configuration write. Other behaviour can only be shown by the bench's scenarios. These include data order and integrity, the exact capacity each chunk range gives, wrap-around from the last chunk to the first without damage to neighbouring queues, and which cycles see a bank clash. The bench predicts each of these from the queue layout and the running sequence counts.

// File: rtl/oqm_pkg.sv
// Shared types and helpers for the output queue manager.
// Assumes a 1024-entry window split into 32 chunks of 32 entries.
package oqm_pkg;
    localparam int OFF_W   = 5;
    localparam int CHUNK_W = 5;
    localparam int WIN_W   = OFF_W + CHUNK_W;

    typedef logic [CHUNK_W-1:0] chunk_t;
    typedef logic [WIN_W-1:0]   win_ptr_t;
    typedef logic [WIN_W:0]     occ_t;

    // Step a window pointer by one entry, returning to the first chunk after the last chunk's top entry.
    function automatic win_ptr_t ptr_advance(win_ptr_t p, chunk_t first, chunk_t last);
        if (p[OFF_W-1:0] == {OFF_W{1'b1}} && p[WIN_W-1:OFF_W] == last)
            return {first, {OFF_W{1'b0}}};
        return p + win_ptr_t'(1);
    endfunction

    // Number of entries covered by chunks first..last inclusive.
    function automatic occ_t chunk_capacity(chunk_t first, chunk_t last);
        occ_t n;
        n = occ_t'(last) - occ_t'(first) + occ_t'(1);
        return n << OFF_W;
    endfunction
endpackage

// File: rtl/oqm_sram_bank.sv
// One single-port SRAM bank: one read or one write per cycle.
// Reads return data on the next cycle. Write wins if both are asked (the caller never does).
module oqm_sram_bank #(
    parameter int ROW_W  = 9,
    parameter int DATA_W = 32,
    localparam int DEPTH = 1 << ROW_W
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [ROW_W-1:0]  row,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Storage access: write on we, otherwise registered read.
    always_ff @(posedge clk) begin
        if (en) begin
            if (we) mem[row] <= wdata;
            else    rdata    <= mem[row];
        end
    end
endmodule

// File: rtl/oqm_bank_array.sv
// Interleaved buffer made of NUM_BANKS single-port banks.
// Assumes the caller never sends a read and a write to the same bank in one cycle.
module oqm_bank_array #(
    parameter int NUM_BANKS = 8,
    parameter int ROW_W     = 9,
    parameter int DATA_W    = 32,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [BANK_W-1:0] rd_bank,
    input  logic [ROW_W-1:0]  rd_row,
    input  logic              wr_en,
    input  logic [BANK_W-1:0] wr_bank,
    input  logic [ROW_W-1:0]  wr_row,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] bank_dout [NUM_BANKS];
    logic [BANK_W-1:0] rd_bank_q;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic rd_hit, wr_hit;
        assign rd_hit = rd_en && rd_bank == BANK_W'(b);
        assign wr_hit = wr_en && wr_bank == BANK_W'(b);
        oqm_sram_bank #(.ROW_W(ROW_W), .DATA_W(DATA_W)) u_bank (
            .clk   (clk),
            .en    (rd_hit || wr_hit),
            .we    (wr_hit && !rd_hit),
            .row   (rd_hit ? rd_row : wr_row),
            .wdata (wr_data),
            .rdata (bank_dout[b])
        );
    end

    // Remember which bank was read so the result can be selected next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_bank_q <= '0;
        else if (rd_en) rd_bank_q <= rd_bank;
    end

    assign rd_data = bank_dout[rd_bank_q];
endmodule

// File: rtl/oqm_qtable.sv
// Per-queue configuration, head/tail pointers and occupancy.
// Assumes each queue's last chunk is not below its first chunk.
// A configuration write overrides a same-cycle push or pop to that queue.
module oqm_qtable
    import oqm_pkg::*;
#(
    parameter int NUM_Q  = 16,
    parameter int BASE_W = 2,
    localparam int QID_W  = $clog2(NUM_Q),
    localparam int ADDR_W = BASE_W + WIN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [QID_W-1:0]  cfg_qid,
    input  logic [BASE_W-1:0] cfg_base,
    input  chunk_t            cfg_start,
    input  chunk_t            cfg_end,
    input  logic              push,
    input  logic [QID_W-1:0]  push_qid,
    input  logic              pop,
    input  logic [QID_W-1:0]  pop_qid,
    output logic [ADDR_W-1:0] push_addr,
    output logic [ADDR_W-1:0] pop_addr,
    output logic [NUM_Q-1:0]  full,
    output logic [NUM_Q-1:0]  empty
);
    logic [BASE_W-1:0] base_a [NUM_Q];
    win_ptr_t          head_a [NUM_Q];
    win_ptr_t          tail_a [NUM_Q];

    for (genvar q = 0; q < NUM_Q; q++) begin : g_q
        logic [BASE_W-1:0] base_r;
        chunk_t            first_r, last_r;
        win_ptr_t          head_r, tail_r;
        occ_t              cnt_r;
        logic              cfg_hit, push_hit, pop_hit;

        assign cfg_hit  = cfg_we && cfg_qid == QID_W'(q);
        assign push_hit = push && push_qid == QID_W'(q);
        assign pop_hit  = pop && pop_qid == QID_W'(q);

        // Queue state update: reset, reconfigure, or advance on push/pop.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_r  <= '0;
                first_r <= '0;
                last_r  <= '0;
                head_r  <= '0;
                tail_r  <= '0;
                cnt_r   <= '0;
            end else if (cfg_hit) begin
                base_r  <= cfg_base;
                first_r <= cfg_start;
                last_r  <= cfg_end;
                head_r  <= {cfg_start, {OFF_W{1'b0}}};
                tail_r  <= {cfg_start, {OFF_W{1'b0}}};
                cnt_r   <= '0;
            end else begin
                if (push_hit) tail_r <= ptr_advance(tail_r, first_r, last_r);
                if (pop_hit)  head_r <= ptr_advance(head_r, first_r, last_r);
                if (push_hit && !pop_hit)      cnt_r <= cnt_r + occ_t'(1);
                else if (pop_hit && !push_hit) cnt_r <= cnt_r - occ_t'(1);
            end
        end

        assign full[q]   = cnt_r == chunk_capacity(first_r, last_r);
        assign empty[q]  = cnt_r == '0;
        assign base_a[q] = base_r;
        assign head_a[q] = head_r;
        assign tail_a[q] = tail_r;
    end

    assign push_addr = {base_a[push_qid], tail_a[push_qid]};
    assign pop_addr  = {base_a[pop_qid], head_a[pop_qid]};
endmodule

// File: rtl/oqm_top.sv
// Output queue manager: circular queues in a shared banked buffer.
// Assumes queues sharing a window are configured with non-overlapping chunk ranges.
// A rejected request (full/empty) or a stalled enqueue leaves all state unchanged.
module oqm_top
    import oqm_pkg::*;
#(
    parameter int NUM_Q     = 16,
    parameter int BASE_W    = 2,
    parameter int DATA_W    = 32,
    parameter int NUM_BANKS = 8,
    localparam int QID_W    = $clog2(NUM_Q),
    localparam int ADDR_W   = BASE_W + WIN_W,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int ROW_W    = ADDR_W - BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [QID_W-1:0]  cfg_qid,
    input  logic [BASE_W-1:0] cfg_base,
    input  logic [4:0]        cfg_start,
    input  logic [4:0]        cfg_end,
    input  logic              enq_valid,
    input  logic [QID_W-1:0]  enq_qid,
    input  logic [DATA_W-1:0] enq_data,
    output logic              enq_ready,
    output logic              enq_err,
    input  logic              deq_valid,
    input  logic [QID_W-1:0]  deq_qid,
    output logic              deq_err,
    output logic              rd_valid,
    output logic [QID_W-1:0]  rd_qid,
    output logic [DATA_W-1:0] rd_data,
    output logic [NUM_Q-1:0]  q_full,
    output logic [NUM_Q-1:0]  q_empty
);
    logic [ADDR_W-1:0] tail_addr, head_addr;
    logic              deq_go, enq_go, bank_clash;

    assign deq_go     = deq_valid && !q_empty[deq_qid];
    assign bank_clash = deq_go && tail_addr[BANK_W-1:0] == head_addr[BANK_W-1:0];
    assign enq_ready  = !bank_clash;
    assign enq_go     = enq_valid && !q_full[enq_qid] && !bank_clash;
    assign enq_err    = enq_valid && q_full[enq_qid];
    assign deq_err    = deq_valid && q_empty[deq_qid];

    oqm_qtable #(.NUM_Q(NUM_Q), .BASE_W(BASE_W)) u_qtable (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_qid   (cfg_qid),
        .cfg_base  (cfg_base),
        .cfg_start (cfg_start),
        .cfg_end   (cfg_end),
        .push      (enq_go),
        .push_qid  (enq_qid),
        .pop       (deq_go),
        .pop_qid   (deq_qid),
        .push_addr (tail_addr),
        .pop_addr  (head_addr),
        .full      (q_full),
        .empty     (q_empty)
    );

    oqm_bank_array #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .DATA_W(DATA_W)) u_banks (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (deq_go),
        .rd_bank (head_addr[BANK_W-1:0]),
        .rd_row  (head_addr[ADDR_W-1:BANK_W]),
        .wr_en   (enq_go),
        .wr_bank (tail_addr[BANK_W-1:0]),
        .wr_row  (tail_addr[ADDR_W-1:BANK_W]),
        .wr_data (enq_data),
        .rd_data (rd_data)
    );

    // Read-return tag: valid and queue id one cycle after an accepted dequeue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_qid   <= '0;
        end else begin
            rd_valid <= deq_go;
            if (deq_go) rd_qid <= deq_qid;
        end
    end
endmodule

// File: rtl/oqm_chk.sv
// Protocol checker for oqm_top, attached by bind.
module oqm_chk #(
    parameter int NUM_Q = 16,
    parameter int QID_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [QID_W-1:0] cfg_qid,
    input logic             enq_valid,
    input logic [QID_W-1:0] enq_qid,
    input logic             enq_ready,
    input logic             enq_err,
    input logic             deq_valid,
    input logic [QID_W-1:0] deq_qid,
    input logic             deq_err,
    input logic             rd_valid,
    input logic [QID_W-1:0] rd_qid,
    input logic [NUM_Q-1:0] q_full,
    input logic [NUM_Q-1:0] q_empty
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (q_empty == {NUM_Q{1'b1}} && q_full == '0 && !rd_valid));

    // R2
    flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_full & q_empty) == '0);

    // R5
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_valid && enq_err && !deq_valid && !cfg_we) |=> q_full[$past(enq_qid)]);

    // R6
    empty_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (deq_valid && deq_err) |=> !rd_valid);

    // R8
    stall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enq_ready |-> (deq_valid && !deq_err));

    // R9
    rd_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (deq_valid && !deq_err) |=> (rd_valid && rd_qid == $past(deq_qid)));

    // R9
    rd_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !deq_valid |=> !rd_valid);

    // R10
    cfg_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (q_empty[$past(cfg_qid)] && !q_full[$past(cfg_qid)]));
endmodule

bind oqm_top oqm_chk #(.NUM_Q(NUM_Q), .QID_W(QID_W)) u_chk (.*);

// File: tb/tb_oqm_top.sv
module tb_oqm_top;
    localparam int CLK_PERIOD = 10;
    localparam int NQ = 16;
    localparam int QW = 4;
    localparam int BW = 2;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [QW-1:0] cfg_qid = '0;
    logic [BW-1:0] cfg_base = '0;
    logic [4:0]    cfg_start = '0, cfg_end = '0;
    logic          enq_valid = 1'b0;
    logic [QW-1:0] enq_qid = '0;
    logic [DW-1:0] enq_data = '0;
    logic          enq_ready, enq_err;
    logic          deq_valid = 1'b0;
    logic [QW-1:0] deq_qid = '0;
    logic          deq_err, rd_valid;
    logic [QW-1:0] rd_qid;
    logic [DW-1:0] rd_data;
    logic [NQ-1:0] q_full, q_empty;

    oqm_top #(.NUM_Q(NQ), .BASE_W(BW), .DATA_W(DW)) dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_fail = 0;
    int mc[NQ], es[NQ], ds[NQ];

    function automatic int cap(int q);   return (q % 3 + 1) * 32; endfunction
    function automatic int basev(int q); return q % 4; endfunction
    function automatic int stc(int q);   return (q / 4) * 8; endfunction
    function automatic logic [DW-1:0] mk(int q, int s);
        return {8'(q), 24'(s)};
    endfunction
    // Physical bank of the entry at offset off of queue q (R7: address bits 2:0).
    function automatic int bank_of(int q, int off);
        int a;
        a = basev(q) * 1024 + stc(q) * 32 + (off % cap(q));
        return a % 8;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic flags(input int q, input string req);
        chk(q_full[q] == (mc[q] == cap(q)), req, $sformatf("full q%0d", q), q_full[q], mc[q] == cap(q));
        chk(q_empty[q] == (mc[q] == 0), req, $sformatf("empty q%0d", q), q_empty[q], mc[q] == 0);
    endtask

    // Configure queue q with its layout and reset the model (R10).
    task automatic do_cfg(input int q);
        cfg_we = 1'b1; cfg_qid = QW'(q); cfg_base = BW'(basev(q));
        cfg_start = 5'(stc(q)); cfg_end = 5'(stc(q) + q % 3);
        @(posedge clk); #1;
        cfg_we = 1'b0;
        mc[q] = 0; es[q] = 0; ds[q] = 0;
        flags(q, "R10");
    endtask

    // One cycle with optional enqueue to qe and dequeue from qd; predicts all outcomes.
    task automatic cyc(input bit ev, input int qe, input bit dv, input int qd, input string req);
        bit full_e, deq_ok, clash, enq_ok;
        full_e = ev && mc[qe] == cap(qe);
        deq_ok = dv && mc[qd] > 0;
        clash  = ev && deq_ok && bank_of(qe, es[qe]) == bank_of(qd, ds[qd]);
        enq_ok = ev && !full_e && !clash;
        enq_valid = ev; enq_qid = QW'(qe); enq_data = mk(qe, es[qe]);
        deq_valid = dv; deq_qid = QW'(qd);
        #(CLK_PERIOD/2 - 1);
        if (ev) begin
            chk(enq_err == full_e, full_e ? "R5" : req, "enq_err", enq_err, full_e);
            chk(enq_ready == !clash, clash ? "R8" : "R7", "enq_ready", enq_ready, !clash);
        end
        if (dv) chk(deq_err == !deq_ok, deq_ok ? req : "R6", "deq_err", deq_err, !deq_ok);
        @(posedge clk); #1;
        enq_valid = 1'b0; deq_valid = 1'b0;
        if (enq_ok) begin mc[qe]++; es[qe]++; end
        if (deq_ok) mc[qd]--;
        chk(rd_valid == deq_ok, deq_ok ? "R9" : "R6", "rd_valid", rd_valid, deq_ok);
        if (deq_ok) begin
            chk(rd_qid == QW'(qd), "R9", "rd_qid", rd_qid, qd);
            chk(rd_data == mk(qd, ds[qd]), req, $sformatf("rd_data q%0d", qd), rd_data, mk(qd, ds[qd]));
            ds[qd]++;
        end
        if (ev) flags(qe, "R2");
        if (dv) flags(qd, "R2");
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        chk(1'b0, "WATCHDOG", "timeout", 0, 1);
        summary();
    end

    initial begin
        for (int q = 0; q < NQ; q++) begin mc[q] = 0; es[q] = 0; ds[q] = 0; end
        repeat (3) @(posedge clk);
        #1;
        // R1: state during reset
        chk(q_empty == {NQ{1'b1}}, "R1", "empty in reset", q_empty, {NQ{1'b1}});
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk(q_empty == {NQ{1'b1}}, "R1", "empty after reset", q_empty, {NQ{1'b1}});
        chk(q_full == '0, "R1", "full after reset", q_full, 0);
        chk(rd_valid == 1'b0, "R1", "rd_valid after reset", rd_valid, 0);

        for (int q = 0; q < NQ; q++) do_cfg(q);

        // R3: short traffic so that later fills cross the wrap point
        for (int q = 0; q < NQ; q++) begin
            for (int i = 0; i < 5; i++) cyc(1, q, 0, 0, "R3");
            for (int i = 0; i < 5; i++) cyc(0, 0, 1, q, "R3");
        end
        // R2, R4: fill every queue to capacity; the tails wrap past the last chunk
        for (int q = 0; q < NQ; q++)
            for (int i = 0; i < cap(q); i++) cyc(1, q, 0, 0, "R2");
        // R5: one more enqueue per full queue is refused
        for (int q = 0; q < NQ; q++) cyc(1, q, 0, 0, "R5");
        // R4: drain all; neighbours in the same window must be intact
        for (int q = 0; q < NQ; q++)
            for (int i = 0; i < cap(q); i++) cyc(0, 0, 1, q, "R4");
        // R6: a dequeue from an empty queue is refused
        for (int q = 0; q < NQ; q++) cyc(0, 0, 1, q, "R6");

        // R7: same queue, different banks
        for (int i = 0; i < 3; i++) cyc(1, 1, 0, 0, "R7");
        for (int i = 0; i < 20; i++) cyc(1, 1, 1, 1, "R7");
        // R8: eight apart means same bank on the first cycle
        for (int i = 0; i < 8; i++) cyc(1, 0, 0, 0, "R8");
        for (int i = 0; i < 12; i++) cyc(1, 0, 1, 0, "R8");
        // R7, R8: cross-queue pairs with sweeping offsets
        for (int i = 0; i < 40; i++) cyc(1, 4, 1, 0, "R7");
        for (int q = 0; q < NQ; q++)
            while (mc[q] > 0) cyc(0, 0, 1, q, "R3");

        // R10: reconfiguring a loaded queue empties it
        for (int i = 0; i < 10; i++) cyc(1, 5, 0, 0, "R10");
        do_cfg(5);
        cyc(0, 0, 1, 5, "R10");
        cyc(1, 5, 0, 0, "R10");
        cyc(0, 0, 1, 5, "R10");

        summary();
    end
endmodule